// File: doc/BRIEF.md
# Defect-Tolerant Cluster Routing Crossbar

This block is the local interconnect of one logic cluster. Four downward boxes steer cluster inputs, cluster-output feedback and a distributed feedback tap onto the 40 logic-block inputs. One upward box steers the 10 logic-block outputs onto the 12 cluster outputs. Routing selects come from configuration memory, which is outside the block and assumed fault-free. Each multiplexer is modelled as an N:1 selection. A multiplexer that is flagged defective drives an unknown value and is never used to carry a route.

After test and diagnosis, a per-multiplexer defect map is written through a word-wide port and then committed with a done strobe. Each downward route has a duplicated output stage that takes over when the primary stage is flagged. The upward box has parallel spare multiplexers that are handed to flagged primaries in ascending route order. A route that cannot be repaired raises its error flag and drives 0. The routing itself is combinational. Every output and every error flag is held at 0 until the map has been committed.

Top module: `cluster_xbar`

## Requirements
- R1: While reset is active and immediately after it is released, the whole defect map is clear, `map_ready_o` is 0, and every routed output and every error flag is 0.
- R2: When `map_we_i` is high at a clock edge, bit `map_addr_i` of the map takes the value of `map_bit_i`. Addresses of 93 and above are ignored. The map layout is: primary stage of downward route m at address m (0..39), duplicate stage of route m at 40+m, upward primary k at 80+k (0..11), spare at 92. A write also clears `map_ready_o` at that edge. A `map_done_i` without a write sets `map_ready_o` at that edge. While `map_ready_o` is 0, all outputs and error flags are 0.
- R3: Downward route m = b*4+j serves input j of logic block b and belongs to box j. With select s from `dn_sel_i[m*5 +: 5]`, a value of s in 0..5 routes `cl_in_i[j*6+s]` to `lb_in_o[m]`.
- R4: A select s of 6..17 routes the upward output `cl_out_o[s-6]` back to `lb_in_o[m]` (feedback).
- R5: A select of 18 routes `lb_out_i[0]` straight into every downward box (distributed feedback). A select of 19..31 gives 0.
- R6: `cl_out_o[k]` carries `lb_out_i[t]`, where t is the select in `up_sel_i[k*4 +: 4]`. A select of 10..15 gives 0.
- R7: When only the primary stage of a downward route is flagged, the duplicate stage carries the same value and `dn_err_o[m]` stays 0.
- R8: When both stages of a downward route are flagged, `dn_err_o[m]` is 1 and `lb_in_o[m]` is 0.
- R9: A flagged upward primary takes the spare if the spare is healthy and has not been given to a lower-numbered flagged route. The output value is then unchanged and `up_err_o[k]` is 0.
- R10: A flagged upward primary that cannot get a spare, because the spare is taken or flagged, sets `up_err_o[k]` and drives `cl_out_o[k]` to 0.
- R11: While `map_ready_o` is 1, no bit of `lb_in_o` or `cl_out_o` is unknown, even when flagged multiplexers are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_we_i | input | 1 | Defect map write strobe |
| map_addr_i | input | 7 | Defect map bit address |
| map_bit_i | input | 1 | Defect flag to write (1 = defective) |
| map_done_i | input | 1 | Commit the map and enable routing |
| map_ready_o | output | 1 | Map committed, outputs valid |
| cl_in_i | input | 24 | Cluster inputs, 6 per downward box |
| lb_out_i | input | 10 | Logic-block outputs |
| dn_sel_i | input | 200 | Downward selects, 5 bits per route |
| up_sel_i | input | 48 | Upward selects, 4 bits per cluster output |
| lb_in_o | output | 40 | Logic-block inputs, route m = b*4+j |
| cl_out_o | output | 12 | Cluster outputs |
| dn_err_o | output | 40 | Downward route cannot be repaired |
| up_err_o | output | 12 | Upward route cannot be repaired |

## Verification
Feedback ties the two boxes together in the same evaluation. A downward route that selects feedback depends on an upward route that may be running on the spare, so repair in the upward box and steering in the downward box meet in one combinational pass. The bench provokes this by flagging upward primaries, one of which is repaired and one of which is not, while downward selects sweep the whole feedback range. Every logic-block input is then compared with a model that first resolves the spare allocation arithmetically and then applies the downward select.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int DEF_N_IN    = 24;
  localparam int DEF_N_DBOX  = 4;
  localparam int DEF_N_LB    = 10;
  localparam int DEF_N_OUT   = 12;
  localparam int DEF_N_SPARE = 1;
  localparam int DEF_N_DF    = 1;

  function automatic int clog2_min1(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xbar_mux.sv
module xbar_mux #(
  parameter int W  = 4,
  parameter int SW = 2
) (
  input  logic [W-1:0]  d_i,
  input  logic [SW-1:0] sel_i,
  input  logic          defect_i,
  output logic          y_o
);
  logic v;
  always_comb begin
    v = 1'b0;
    for (int i = 0; i < W; i++)
      if (int'(sel_i) == i) v = d_i[i];
  end
  // stuck-open model: a flagged mux never drives a known level
  assign y_o = defect_i ? 1'bx : v;
endmodule

// File: rtl/xbar_defect_map.sv
module xbar_defect_map #(
  parameter int MAP_N = 8,
  parameter int AW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             bit_i,
  input  logic             done_i,
  output logic [MAP_N-1:0] map_o,
  output logic             ready_o
);
  logic [MAP_N-1:0] map_q;
  logic             ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      for (int i = 0; i < MAP_N; i++)
        if (we_i && int'(addr_i) == i) map_q[i] <= bit_i;
      if (we_i)        ready_q <= 1'b0;
      else if (done_i) ready_q <= 1'b1;
    end
  end

  assign map_o   = map_q;
  assign ready_o = ready_q;

  assert_done_sets_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !we_i) |=> ready_o);
  assert_write_clears_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !ready_o);
endmodule

// File: rtl/xbar_dn_box.sv
module xbar_dn_box #(
  parameter int N_LB  = 10,
  parameter int IPB   = 6,
  parameter int N_OUT = 12,
  parameter int N_DF  = 1,
  parameter int DFW   = 1,
  parameter int W     = IPB + N_OUT + N_DF,
  parameter int SW    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IPB-1:0]     cin_i,
  input  logic [N_OUT-1:0]   fb_i,
  input  logic [DFW-1:0]     df_i,
  input  logic [N_LB*SW-1:0] sel_i,
  input  logic [N_LB-1:0]    def_a_i,
  input  logic [N_LB-1:0]    def_b_i,
  output logic [N_LB-1:0]    y_o,
  output logic [N_LB-1:0]    err_o
);
  logic [W-1:0] data;

  generate
    if (N_DF > 0) begin : g_df
      assign data = {df_i[N_DF-1:0], fb_i, cin_i};
    end else begin : g_nodf
      assign data = {fb_i, cin_i};
    end
  endgenerate

  for (genvar b = 0; b < N_LB; b++) begin : g_mux
    logic ya, yb;
    xbar_mux #(.W(W), .SW(SW)) i_pri (
      .d_i(data), .sel_i(sel_i[b*SW +: SW]), .defect_i(def_a_i[b]), .y_o(ya));
    xbar_mux #(.W(W), .SW(SW)) i_dup (
      .d_i(data), .sel_i(sel_i[b*SW +: SW]), .defect_i(def_b_i[b]), .y_o(yb));

    assign err_o[b] = def_a_i[b] & def_b_i[b];
    assign y_o[b]   = !def_a_i[b] ? ya : (!def_b_i[b] ? yb : 1'b0);

    assert_dn_known_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$isunknown(y_o[b]));
    assert_dn_dup_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!def_a_i[b] && !def_b_i[b]) |-> (ya == yb));
  end
endmodule

// File: rtl/xbar_up_box.sv
module xbar_up_box #(
  parameter int N_LB    = 10,
  parameter int N_OUT   = 12,
  parameter int N_SPARE = 1,
  parameter int SW      = 4,
  parameter int SPW     = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_LB-1:0]     lb_i,
  input  logic [N_OUT*SW-1:0] sel_i,
  input  logic [N_OUT-1:0]    def_p_i,
  input  logic [N_SPARE-1:0]  def_s_i,
  output logic [N_OUT-1:0]    y_o,
  output logic [N_OUT-1:0]    err_o
);
  logic [N_OUT-1:0]      p_y, use_sp;
  logic [N_SPARE-1:0]    sp_y, sp_busy;
  logic [N_SPARE*SW-1:0] sp_sel;
  logic [SPW-1:0]        sp_idx [N_OUT];

  // hand spares to flagged routes in ascending route order
  always_comb begin
    logic found;
    sp_busy = '0;
    sp_sel  = '0;
    use_sp  = '0;
    err_o   = '0;
    for (int k = 0; k < N_OUT; k++) begin
      sp_idx[k] = '0;
      found     = 1'b0;
      if (def_p_i[k]) begin
        for (int s = 0; s < N_SPARE; s++) begin
          if (!found && !def_s_i[s] && !sp_busy[s]) begin
            found               = 1'b1;
            sp_busy[s]          = 1'b1;
            sp_sel[s*SW +: SW]  = sel_i[k*SW +: SW];
            sp_idx[k]           = SPW'(s);
            use_sp[k]           = 1'b1;
          end
        end
        if (!found) err_o[k] = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_pri
    xbar_mux #(.W(N_LB), .SW(SW)) i_mux (
      .d_i(lb_i), .sel_i(sel_i[k*SW +: SW]), .defect_i(def_p_i[k]), .y_o(p_y[k]));
    assign y_o[k] = err_o[k] ? 1'b0 : (use_sp[k] ? sp_y[sp_idx[k]] : p_y[k]);

    assert_up_known_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$isunknown(y_o[k]));
  end

  for (genvar s = 0; s < N_SPARE; s++) begin : g_spare
    xbar_mux #(.W(N_LB), .SW(SW)) i_mux (
      .d_i(lb_i), .sel_i(sp_sel[s*SW +: SW]), .defect_i(def_s_i[s]), .y_o(sp_y[s]));
  end

  assert_spare_accounting_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(err_o) + $countones(sp_busy)) == $countones(def_p_i));
  assert_spare_healthy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_busy & def_s_i) == '0);
endmodule

// File: rtl/cluster_xbar.sv
module cluster_xbar
  import xbar_pkg::*;
#(
  parameter int N_IN    = DEF_N_IN,
  parameter int N_DBOX  = DEF_N_DBOX,
  parameter int N_LB    = DEF_N_LB,
  parameter int N_OUT   = DEF_N_OUT,
  parameter int N_SPARE = DEF_N_SPARE,
  parameter int N_DF    = DEF_N_DF,
  localparam int LB_IN  = N_DBOX,
  localparam int IPB    = N_IN / N_DBOX,
  localparam int N_DN   = N_LB * LB_IN,
  localparam int DN_W   = IPB + N_OUT + N_DF,
  localparam int DN_SW  = clog2_min1(DN_W),
  localparam int UP_SW  = clog2_min1(N_LB),
  localparam int SPW    = clog2_min1(N_SPARE),
  localparam int DFW    = (N_DF > 0) ? N_DF : 1,
  localparam int A_DUP  = N_DN,
  localparam int A_UP   = 2 * N_DN,
  localparam int A_SP   = 2 * N_DN + N_OUT,
  localparam int MAP_N  = A_SP + N_SPARE,
  localparam int AW     = clog2_min1(MAP_N)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   map_we_i,
  input  logic [AW-1:0]          map_addr_i,
  input  logic                   map_bit_i,
  input  logic                   map_done_i,
  output logic                   map_ready_o,
  input  logic [N_IN-1:0]        cl_in_i,
  input  logic [N_LB-1:0]        lb_out_i,
  input  logic [N_DN*DN_SW-1:0]  dn_sel_i,
  input  logic [N_OUT*UP_SW-1:0] up_sel_i,
  output logic [N_DN-1:0]        lb_in_o,
  output logic [N_OUT-1:0]       cl_out_o,
  output logic [N_DN-1:0]        dn_err_o,
  output logic [N_OUT-1:0]       up_err_o
);
  logic [MAP_N-1:0] map;
  logic             ready;
  logic [N_OUT-1:0] up_y, up_err;
  logic [N_DN-1:0]  dn_y, dn_err;
  logic [DFW-1:0]   df;

  xbar_defect_map #(.MAP_N(MAP_N), .AW(AW)) i_map (
    .clk_i, .rst_ni, .we_i(map_we_i), .addr_i(map_addr_i), .bit_i(map_bit_i),
    .done_i(map_done_i), .map_o(map), .ready_o(ready));

  xbar_up_box #(.N_LB(N_LB), .N_OUT(N_OUT), .N_SPARE(N_SPARE), .SW(UP_SW), .SPW(SPW)) i_up (
    .clk_i, .rst_ni, .lb_i(lb_out_i), .sel_i(up_sel_i),
    .def_p_i(map[A_UP +: N_OUT]), .def_s_i(map[A_SP +: N_SPARE]),
    .y_o(up_y), .err_o(up_err));

  assign df = lb_out_i[DFW-1:0];

  for (genvar j = 0; j < N_DBOX; j++) begin : g_box
    logic [N_LB*DN_SW-1:0] sel;
    logic [N_LB-1:0]       def_a, def_b, y, err;
    for (genvar b = 0; b < N_LB; b++) begin : g_lb
      assign sel[b*DN_SW +: DN_SW] = dn_sel_i[(b*LB_IN+j)*DN_SW +: DN_SW];
      assign def_a[b]              = map[b*LB_IN+j];
      assign def_b[b]              = map[A_DUP+b*LB_IN+j];
      assign dn_y[b*LB_IN+j]       = y[b];
      assign dn_err[b*LB_IN+j]     = err[b];
    end
    xbar_dn_box #(.N_LB(N_LB), .IPB(IPB), .N_OUT(N_OUT), .N_DF(N_DF), .DFW(DFW),
                  .W(DN_W), .SW(DN_SW)) i_dn (
      .clk_i, .rst_ni, .cin_i(cl_in_i[j*IPB +: IPB]), .fb_i(up_y), .df_i(df),
      .sel_i(sel), .def_a_i(def_a), .def_b_i(def_b), .y_o(y), .err_o(err));
  end

  assign map_ready_o = ready;
  assign lb_in_o     = ready ? dn_y   : '0;
  assign cl_out_o    = ready ? up_y   : '0;
  assign dn_err_o    = ready ? dn_err : '0;
  assign up_err_o    = ready ? up_err : '0;

  assert_ready_needs_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(map_ready_o) |-> $past(map_done_i));
  assert_dn_err_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_err_o & lb_in_o) == '0);
  assert_up_err_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_err_o & cl_out_o) == '0);
endmodule

// File: tb/test_cluster_xbar.sv
module test_cluster_xbar;
  localparam int CLK_PERIOD = 10;
  localparam int N_DN  = 40;
  localparam int N_OUT = 12;
  localparam int A_DUP = 40, A_UP = 80, A_SP = 92, MAP_N = 93;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic map_we = 0, map_bit = 0, map_done = 0, map_ready;
  logic [6:0] map_addr = '0;
  logic [23:0] cl_in = '0;
  logic [9:0]  lb_out = '0;
  logic [199:0] dn_sel = '0;
  logic [47:0]  up_sel = '0;
  logic [39:0] lb_in, dn_err;
  logic [11:0] cl_out, up_err;
  logic [MAP_N-1:0] map_m = '0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_xbar i_cluster_xbar (
    .clk_i(clk), .rst_ni, .map_we_i(map_we), .map_addr_i(map_addr), .map_bit_i(map_bit),
    .map_done_i(map_done), .map_ready_o(map_ready), .cl_in_i(cl_in), .lb_out_i(lb_out),
    .dn_sel_i(dn_sel), .up_sel_i(up_sel), .lb_in_o(lb_in), .cl_out_o(cl_out),
    .dn_err_o(dn_err), .up_err_o(up_err));

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input bit rdy);
    logic [11:0] e_cl, e_ue;
    logic [39:0] e_lb, e_de;
    bit spare_free;
    int s, t;
    #1;
    spare_free = !map_m[A_SP];
    for (int k = 0; k < N_OUT; k++) begin
      t = int'(up_sel[k*4 +: 4]);
      e_cl[k] = (t < 10) ? lb_out[t] : 1'b0;
      e_ue[k] = 1'b0;
      if (map_m[A_UP+k]) begin
        if (spare_free) spare_free = 0;
        else begin e_cl[k] = 1'b0; e_ue[k] = 1'b1; end
      end
    end
    for (int m = 0; m < N_DN; m++) begin
      s = int'(dn_sel[m*5 +: 5]);
      if (s < 6)       e_lb[m] = cl_in[(m%4)*6+s];
      else if (s < 18) e_lb[m] = e_cl[s-6];
      else if (s == 18) e_lb[m] = lb_out[0];
      else             e_lb[m] = 1'b0;
      e_de[m] = map_m[m] & map_m[A_DUP+m];
      if (e_de[m]) e_lb[m] = 1'b0;
    end
    if (!rdy) begin e_cl = '0; e_ue = '0; e_lb = '0; e_de = '0; end
    chk(tag, "map_ready", 64'(map_ready), 64'(rdy));
    chk(tag, "cl_out", 64'(cl_out), 64'(e_cl));
    chk(tag, "up_err", 64'(up_err), 64'(e_ue));
    chk(tag, "lb_in", 64'(lb_in), 64'(e_lb));
    chk(tag, "dn_err", 64'(dn_err), 64'(e_de));
    checks++;
    if ($isunknown({lb_in, cl_out})) begin
      errors++;
      $display("FAIL R11 unknown output actual %h_%h expected known", lb_in, cl_out);
    end
  endtask

  task automatic wr(input int a, input logic v);
    @(negedge clk); map_we = 1; map_addr = 7'(a); map_bit = v;
    @(negedge clk); map_we = 0;
    if (a < MAP_N) map_m[a] = v;
  endtask

  task automatic commit();
    @(negedge clk); map_done = 1;
    @(negedge clk); map_done = 0;
  endtask

  task automatic rand_data();
    cl_in  = 24'($urandom);
    lb_out = 10'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < N_OUT; k++) up_sel[k*4 +: 4] = 4'(k % 10);
    check_all("R1", 0);
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    rand_data();
    check_all("R1", 0);

    // selects set but map not committed: outputs stay zero
    for (int m = 0; m < N_DN; m++) dn_sel[m*5 +: 5] = 5'(m % 19);
    check_all("R2", 0);
    commit();
    check_all("R2", 1);
    wr(120, 1'b1);               // out-of-range address ignored, ready dropped
    check_all("R2", 0);
    commit();
    check_all("R2", 1);

    // upward sweep
    for (int k = 0; k < N_OUT; k++)
      for (int t = 0; t < 16; t++)
        for (int p = 0; p < 3; p++) begin
          lb_out = (p == 0) ? 10'h2A5 : (p == 1) ? 10'h15A : 10'(1 << (t % 10));
          up_sel[k*4 +: 4] = 4'(t);
          check_all("R6", 1);
          up_sel[k*4 +: 4] = 4'(k % 10);
        end

    // downward sweep over cluster inputs, feedback and distributed feedback
    for (int m = 0; m < N_DN; m++)
      for (int s = 0; s < 32; s++) begin
        rand_data();
        dn_sel[m*5 +: 5] = 5'(s);
        check_all(s < 6 ? "R3" : (s < 18 ? "R4" : "R5"), 1);
      end

    // downward repair
    wr(5, 1'b1);
    wr(A_DUP+9, 1'b1);
    wr(7, 1'b1); wr(A_DUP+7, 1'b1);
    commit();
    for (int s = 0; s < 32; s++) begin
      rand_data();
      dn_sel[5*5 +: 5] = 5'(s); dn_sel[7*5 +: 5] = 5'(s); dn_sel[9*5 +: 5] = 5'(s);
      check_all(s == 7 ? "R8" : "R7", 1);
    end

    // upward repair: route 3 takes the spare, route 8 errors
    wr(A_UP+3, 1'b1); wr(A_UP+8, 1'b1);
    commit();
    for (int s = 0; s < 24; s++) begin
      rand_data();
      for (int m = 0; m < N_DN; m++) dn_sel[m*5 +: 5] = 5'(6 + ((m + s) % 12));
      up_sel[3*4 +: 4] = 4'(s % 10); up_sel[8*4 +: 4] = 4'((s + 3) % 10);
      check_all(s[0] ? "R9" : "R10", 1);
    end

    // spare flagged: both routes error
    wr(A_SP, 1'b1);
    commit();
    for (int s = 0; s < 8; s++) begin
      rand_data();
      check_all("R10", 1);
    end

    // spare healthy, only route 8 flagged: it gets the spare
    wr(A_SP, 1'b0); wr(A_UP+3, 1'b0);
    commit();
    for (int s = 0; s < 8; s++) begin
      rand_data();
      check_all("R9", 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule